// File: doc/BRIEF.md
# Timestamped Event Recorder

The block watches an asynchronous, normally-low event input. Each rising edge of that input, once synchronised and let through by the gating configuration, counts as one event. The block then stamps the event with the value of a packed time/date bus that the surrounding clock logic supplies.

The earliest event since the last flush goes into a dedicated "first" slot and stays there. Every later event goes into a small circular history that keeps only the most recent entries. The host reads any stored stamp through a single indexed read port.

An active-low flag drops on each recorded event and stays low until software clears the status bit. A two-bit configuration word enables detection and says whether detection continues while the system runs from its backup supply.

Top module: `evt_stamp_log`

## Requirements
- R1: After reset `evt_n` is 1, `evt_status` is 0, `first_valid` is 0, `hist_count` is 0, every `rd_data` index reads 0, and detection is disabled.
- R2: An event is a 0-to-1 transition of `evt_pin` after a two-flop synchroniser. The flag falls at the third rising clock edge after the pin rises. A pin held high records exactly one event.
- R3: When `first_valid` is 0, an event stores `time_now` into the first slot and sets `first_valid`. The slot reads back at `rd_sel` = 3 and keeps its value until it is flushed.
- R4: While the first slot is valid, each event pushes `time_now` into a three-entry history. `rd_sel` 0 is the newest entry, 1 the next and 2 the oldest. `hist_count` saturates at 3, and a fourth push drops the oldest entry.
- R5: A `rd_sel` value from 0 to 2 that is not below `hist_count` reads 0. `rd_sel` = 3 reads 0 while `first_valid` is 0.
- R6: `evt_n` equals the inverse of `evt_status`. An event sets the status. A one-cycle `status_clr` pulse clears it without changing any stored stamp.
- R7: A `cfg_wr` pulse loads `cfg_wdata`, where bit 0 is the detect enable and bit 1 is run-on-backup. With the enable at 0, pin edges record nothing and leave the flag unchanged.
- R8: While `on_battery` is 1, events are recorded only if run-on-backup is 1. While `on_battery` is 0, run-on-backup has no effect.
- R9: A `first_clr` pulse empties the first slot and sets `hist_count` to 0. The next event then becomes the new first event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pin | input | 1 | Asynchronous event input, active high |
| time_now | input | TS_W | Packed current time and date |
| on_battery | input | 1 | 1 while running from backup supply |
| cfg_wr | input | 1 | Load configuration strobe |
| cfg_wdata | input | 2 | bit0 detect enable, bit1 run-on-backup |
| status_clr | input | 1 | Clear event status strobe |
| first_clr | input | 1 | Flush first slot and history strobe |
| rd_sel | input | RD_W | 0..2 history (0 newest), 3 first slot |
| evt_n | output | 1 | Active-low event flag |
| evt_status | output | 1 | Event status bit |
| first_valid | output | 1 | First slot holds a stamp |
| hist_count | output | CNT_W | Number of valid history entries |
| rd_data | output | TS_W | Selected timestamp |

## Verification
Some properties are checked on every cycle. A qualified event never fires on two consecutive cycles, and the flag stays low until it is cleared. The first stamp stays frozen while it is valid, and the history count never passes its depth. A flush always empties the history, and a closed gate freezes all logging state.

Other behaviour is shown only by the bench's scenarios, each compared against a reference model. These cover the exact stamp values and the newest-first ordering across ring wrap-around. They also cover the drop of the oldest entry, the three-edge latency, and the interaction of enable, run-on-backup and supply mode.

// File: rtl/evt_log_pkg.sv
package evt_log_pkg;

    typedef struct packed {
        logic run_on_bat;
        logic det_en;
    } evt_cfg_t;

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/evt_ring.sv
module evt_ring #(
    parameter int TS_W  = 48,
    parameter int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [TS_W-1:0]  push_data,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [TS_W-1:0]  rd_data,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][TS_W-1:0] mem;
        logic [PTR_W-1:0]           ptr;
        logic [CNT_W-1:0]           cnt;
    } ring_t;

    ring_t r_d, r_q;
    int    slot;

    always_comb begin
        r_d = r_q;
        if (flush) begin
            r_d.cnt = '0;
            r_d.ptr = '0;
        end
        if (push) begin
            r_d.mem[r_d.ptr] = push_data;
            r_d.ptr = (r_d.ptr == PTR_W'(DEPTH - 1)) ? '0 : r_d.ptr + 1'b1;
            if (r_d.cnt != CNT_W'(DEPTH)) r_d.cnt = r_d.cnt + 1'b1;
        end
    end

    always_comb begin
        slot    = (int'(r_q.ptr) + DEPTH - 1 - int'(rd_idx)) % DEPTH;
        rd_data = '0;
        if (rd_idx < r_q.cnt) rd_data = r_q.mem[PTR_W'(slot)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign count = r_q.cnt;
endmodule

// File: rtl/evt_stamp_log.sv
module evt_stamp_log
    import evt_log_pkg::*;
#(
    parameter int TS_W        = 48,
    parameter int DEPTH       = 3,
    parameter int SYNC_STAGES = 2,
    localparam int RD_W  = $clog2(DEPTH + 1),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_pin,
    input  logic [TS_W-1:0]  time_now,
    input  logic             on_battery,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_wdata,
    input  logic             status_clr,
    input  logic             first_clr,
    input  logic [RD_W-1:0]  rd_sel,
    output logic             evt_n,
    output logic             evt_status,
    output logic             first_valid,
    output logic [CNT_W-1:0] hist_count,
    output logic [TS_W-1:0]  rd_data
);
    typedef struct packed {
        evt_cfg_t        cfg;
        logic            prev;
        logic            status;
        logic            first_vld;
        logic [TS_W-1:0] first_ts;
    } log_st_t;

    log_st_t         st_d, st_q;
    logic            pin_s;
    logic            gate_open;
    logic            evt_fire;
    logic            take_first;
    logic            hist_push;
    logic [TS_W-1:0] ring_rd;

    evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (evt_pin),
        .dout (pin_s)
    );

    always_comb begin
        st_d       = st_q;
        st_d.prev  = pin_s;
        gate_open  = st_q.cfg.det_en && (!on_battery || st_q.cfg.run_on_bat);
        evt_fire   = gate_open && pin_s && !st_q.prev;
        take_first = evt_fire && (!st_q.first_vld || first_clr);
        hist_push  = evt_fire && !take_first;

        if (cfg_wr) begin
            st_d.cfg.det_en     = cfg_wdata[0];
            st_d.cfg.run_on_bat = cfg_wdata[1];
        end
        if (status_clr) st_d.status = 1'b0;
        if (first_clr) begin
            st_d.first_vld = 1'b0;
            st_d.first_ts  = '0;
        end
        if (evt_fire) st_d.status = 1'b1;
        if (take_first) begin
            st_d.first_vld = 1'b1;
            st_d.first_ts  = time_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    evt_ring #(.TS_W(TS_W), .DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (first_clr),
        .push     (hist_push),
        .push_data(time_now),
        .rd_idx   (rd_sel),
        .rd_data  (ring_rd),
        .count    (hist_count)
    );

    always_comb begin
        if (rd_sel == RD_W'(DEPTH)) rd_data = st_q.first_vld ? st_q.first_ts : '0;
        else                        rd_data = ring_rd;
    end

    assign evt_status  = st_q.status;
    assign evt_n       = ~st_q.status;
    assign first_valid = st_q.first_vld;
endmodule

// File: rtl/evt_stamp_log_chk.sv
module evt_stamp_log_chk #(
    parameter int TS_W  = 48,
    parameter int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             status_clr,
    input logic             first_clr,
    input logic             evt_fire,
    input logic             gate_open,
    input logic             evt_n,
    input logic             first_valid,
    input logic [TS_W-1:0]  first_ts,
    input logic [CNT_W-1:0] hist_count
);
    assert_single_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_fire |=> !evt_fire);

    assert_flag_on_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_fire |=> !evt_n);

    assert_first_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid && !first_clr |=> first_valid && $stable(first_ts));

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hist_count <= CNT_W'(DEPTH));

    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_n && !status_clr |=> !evt_n);

    assert_gate_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open && !first_clr |=> $stable(hist_count) && $stable(first_valid));

    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        first_clr |=> hist_count == '0);
endmodule

bind evt_stamp_log evt_stamp_log_chk #(.TS_W(TS_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_clr (status_clr),
    .first_clr  (first_clr),
    .evt_fire   (evt_fire),
    .gate_open  (gate_open),
    .evt_n      (evt_n),
    .first_valid(first_valid),
    .first_ts   (st_q.first_ts),
    .hist_count (hist_count)
);

// File: tb/evt_stamp_log_bench.sv
module evt_stamp_log_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TS_W  = 48;
    localparam int DEPTH = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            evt_pin = 1'b0;
    logic [TS_W-1:0] time_now = '0;
    logic            on_battery = 1'b0;
    logic            cfg_wr = 1'b0;
    logic [1:0]      cfg_wdata = '0;
    logic            status_clr = 1'b0;
    logic            first_clr = 1'b0;
    logic [1:0]      rd_sel = '0;
    logic            evt_n, evt_status, first_valid;
    logic [1:0]      hist_count;
    logic [TS_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    bit              m_en, m_run, m_status, m_fv;
    logic [TS_W-1:0] m_first;
    logic [TS_W-1:0] m_hist [DEPTH];
    int              m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_stamp_log #(.TS_W(TS_W), .DEPTH(DEPTH)) u_evt_stamp_log (
        .clk(clk), .rst_n(rst_n), .evt_pin(evt_pin), .time_now(time_now),
        .on_battery(on_battery), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .status_clr(status_clr), .first_clr(first_clr), .rd_sel(rd_sel),
        .evt_n(evt_n), .evt_status(evt_status), .first_valid(first_valid),
        .hist_count(hist_count), .rd_data(rd_data)
    );

    function automatic logic [TS_W-1:0] exp_read(int sel);
        if (sel == DEPTH) return m_fv ? m_first : '0;
        if (sel < m_cnt)  return m_hist[sel];
        return '0;
    endfunction

    function automatic bit exp_accept(bit bat);
        return m_en && (!bat || m_run);
    endfunction

    task automatic chk(string req, logic [TS_W-1:0] act, logic [TS_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk({req, " evt_n"}, TS_W'(evt_n), TS_W'(!m_status));
        chk({req, " status"}, TS_W'(evt_status), TS_W'(m_status));
        chk({req, " first_valid"}, TS_W'(first_valid), TS_W'(m_fv));
        chk({req, " count"}, TS_W'(hist_count), TS_W'(m_cnt));
        for (int s = 0; s <= DEPTH; s++) begin
            rd_sel = 2'(s);
            #1;
            chk({req, " rd_data"}, rd_data, exp_read(s));
        end
    endtask

    task automatic pulse_evt(logic [TS_W-1:0] ts, int hold);
        @(negedge clk);
        time_now = ts;
        evt_pin  = 1'b1;
        repeat (hold) @(negedge clk);
        evt_pin = 1'b0;
        repeat (4) @(negedge clk);
        if (exp_accept(on_battery)) begin
            m_status = 1;
            if (!m_fv) begin
                m_fv = 1; m_first = ts;
            end else begin
                for (int i = DEPTH - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
                m_hist[0] = ts;
                if (m_cnt < DEPTH) m_cnt++;
            end
        end
    endtask

    task automatic strobe_status_clr();
        @(negedge clk); status_clr = 1'b1;
        @(negedge clk); status_clr = 1'b0;
        m_status = 0;
    endtask

    task automatic strobe_first_clr();
        @(negedge clk); first_clr = 1'b1;
        @(negedge clk); first_clr = 1'b0;
        m_fv = 0; m_first = '0; m_cnt = 0;
    endtask

    task automatic write_cfg(bit en, bit run);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = {run, en};
        @(negedge clk); cfg_wr = 1'b0;
        m_en = en; m_run = run;
    endtask

    function automatic logic [TS_W-1:0] rnd_ts();
        return TS_W'({$urandom, $urandom});
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        m_en = 0; m_run = 0; m_status = 0; m_fv = 0; m_first = '0; m_cnt = 0;
        for (int i = 0; i < DEPTH; i++) m_hist[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R7: disabled -> nothing recorded
        pulse_evt(48'h1111, 2);
        check_all("R7 disabled");

        write_cfg(1, 0);
        // R2 latency: flag falls at third edge after pin rise
        @(negedge clk);
        time_now = 48'h0A0B0C; evt_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R2 latency before", TS_W'(evt_n), 1);
        @(negedge clk);
        chk("R2 latency at third edge", TS_W'(evt_n), 0);
        // held high for a long time: one event only
        repeat (20) @(negedge clk);
        evt_pin = 1'b0;
        repeat (4) @(negedge clk);
        m_status = 1; m_fv = 1; m_first = 48'h0A0B0C;
        check_all("R2 R3 held high one event");

        strobe_status_clr();
        check_all("R6 status clear keeps stamps");

        // R4 ring fill and wrap
        pulse_evt(48'h100, 1);
        pulse_evt(48'h200, 1);
        check_all("R4 R5 partial history");
        pulse_evt(48'h300, 1);
        pulse_evt(48'h400, 1);
        pulse_evt(48'h500, 3);
        check_all("R4 wrap drops oldest");

        // R8 battery gating
        @(negedge clk); on_battery = 1'b1;
        pulse_evt(48'hBA7, 1);
        check_all("R8 battery blocked");
        write_cfg(1, 1);
        pulse_evt(48'hBA8, 1);
        check_all("R8 battery allowed");
        @(negedge clk); on_battery = 1'b0;

        // R9 flush then new first
        strobe_first_clr();
        check_all("R9 flushed");
        pulse_evt(48'hF00D, 1);
        check_all("R9 new first");

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op <= 4)      pulse_evt(rnd_ts(), int'($urandom_range(1, 6)));
            else if (op == 5) strobe_status_clr();
            else if (op == 6) strobe_first_clr();
            else if (op == 7) write_cfg(bit'($urandom_range(0, 5) != 0), bit'($urandom_range(0, 1)));
            else begin
                @(negedge clk); on_battery = bit'($urandom_range(0, 1));
            end
            check_all("R3 R4 R6 R7 R8 R9 random");
        end

        finish_run();
    end
endmodule